// File: doc/BRIEF.md
# Register Window Pointer Controller

This block holds the current window pointer and the window invalid mask for a register file that is split into a parameterised number of windows. It also holds the processor status bits that travel with the pointer: supervisor, previous-supervisor, trap-enable, floating-point enable and a 4-bit interrupt level. Commands arrive one per cycle on a single-cycle command port. The command kinds are window save, window restore, return from trap, status write and mask write.

Each command either commits its new state or raises a trap. When it traps, the block changes no state and emits a one-cycle trap pulse with a 2-bit cause. The register storage itself, the movement of wrap registers and trap vectoring all sit outside the block.

Top module: `regwin_ptr`

## Requirements
- R1: After reset the pointer is 0, the mask is all zeros, trap-enable is 0, supervisor is 1, previous-supervisor, FP enable and interrupt level are 0, and no trap pulse is present.
- R2: A save (op 0) whose target window is not masked moves the pointer down by one. From 0 it wraps to NWIN-1.
- R3: A restore (op 1) whose target window is not masked moves the pointer up by one. From NWIN-1 it wraps to 0.
- R4: A save whose target window has its mask bit set raises cause 1 (overflow) and leaves all state unchanged.
- R5: A restore whose target window has its mask bit set raises cause 2 (underflow) and leaves all state unchanged.
- R6: A return from trap (op 2) issued while trap-enable is 1 raises cause 3 (illegal) and leaves state unchanged. This holds even when its target window is masked.
- R7: A return from trap with trap-enable 0 and an unmasked target does three things: it moves the pointer up by one with wrap, sets trap-enable to 1, and copies previous-supervisor into supervisor.
- R8: A return from trap with trap-enable 0 and a masked target raises cause 2 and changes no state. Trap-enable stays 0.
- R9: A status write (op 3) whose pointer field cmdData[4:0] is NWIN or larger raises cause 3 and changes no state.
- R10: A valid status write loads the following fields: pointer from cmdData[4:0], trap-enable from bit 5, previous-supervisor from bit 6, supervisor from bit 7, interrupt level from bits 11:8 and FP enable from bit 12.
- R11: A mask write (op 4) loads the mask from cmdData[NWIN-1:0].
- R12: Outputs reflect a command one clock after the edge that accepts it. The trap pulse lasts exactly one cycle. Cause reads 0 whenever there is no pulse.
- R13: With cmdValid low, or with op codes 5 to 7, nothing changes and no trap is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present this cycle |
| cmdOp | input | 3 | Command kind |
| cmdData | input | max(13,NWIN) | Status word or mask value |
| cwpOut | output | clog2(NWIN) | Current window pointer |
| wimOut | output | NWIN | Window invalid mask |
| supOut | output | 1 | Supervisor bit |
| prevSupOut | output | 1 | Previous-supervisor bit |
| trapEnOut | output | 1 | Trap-enable bit |
| fpEnOut | output | 1 | FP enable bit |
| pilOut | output | 4 | Interrupt level |
| trapPulse | output | 1 | One-cycle trap request |
| trapCause | output | 2 | 0 none, 1 overflow, 2 underflow, 3 illegal |

## Verification
A return from trap can meet two trap conditions in the same cycle: trap-enable is already set, and the target window is masked. The bench builds this case for every pointer value by loading a status word with trap-enable set and a mask that covers the target. It then expects cause 3 and no state change. The opposite case, trap-enable clear with a masked target, must give cause 2 with trap-enable still clear. Both outcomes are compared against a bench model that steps the pointer with modulo arithmetic.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  typedef enum logic [2:0] {
    OP_SAVE    = 3'd0,
    OP_RESTORE = 3'd1,
    OP_RETT    = 3'd2,
    OP_WRSTAT  = 3'd3,
    OP_WRMASK  = 3'd4
  } winOp_e;

  typedef enum logic [1:0] {
    TC_NONE = 2'd0,
    TC_OVF  = 2'd1,
    TC_UNF  = 2'd2,
    TC_ILL  = 2'd3
  } trapCause_e;

  // strobes from control to datapath, at most one set per cycle
  typedef struct packed {
    logic moveDn;
    logic moveUp;
    logic rettDo;
    logic loadStat;
    logic loadMask;
  } winStrb_t;

  // status word layout
  localparam int ST_ET  = 5;
  localparam int ST_PS  = 6;
  localparam int ST_S   = 7;
  localparam int ST_PIL = 8;
  localparam int ST_EF  = 12;
endpackage

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
  import regwin_pkg::*;
#(
  parameter int NWIN = 8,
  localparam int CW = $clog2(NWIN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmdValid,
  input  logic [2:0]      cmdOp,
  input  logic [4:0]      cwpField,
  input  logic [CW-1:0]   cwpIn,
  input  logic [CW-1:0]   cwpUp,
  input  logic [CW-1:0]   cwpDn,
  input  logic [NWIN-1:0] wim,
  input  logic            trapEn,
  output winStrb_t        strb,
  output logic            trapPulse,
  output logic [1:0]      trapCause
);
  localparam logic [5:0] NWIN6 = 6'(NWIN);

  trapCause_e causeNxt;

  always_comb begin
    strb     = '0;
    causeNxt = TC_NONE;
    if (cmdValid) begin
      case (winOp_e'(cmdOp))
        OP_SAVE:    if (wim[cwpDn]) causeNxt = TC_OVF; else strb.moveDn = 1'b1;
        OP_RESTORE: if (wim[cwpUp]) causeNxt = TC_UNF; else strb.moveUp = 1'b1;
        OP_RETT: begin
          if (trapEn)           causeNxt = TC_ILL;
          else if (wim[cwpUp])  causeNxt = TC_UNF;
          else                  strb.rettDo = 1'b1;
        end
        OP_WRSTAT:  if ({1'b0, cwpField} >= NWIN6) causeNxt = TC_ILL; else strb.loadStat = 1'b1;
        OP_WRMASK:  strb.loadMask = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trapPulse <= 1'b0;
      trapCause <= TC_NONE;
    end else begin
      trapPulse <= (causeNxt != TC_NONE);
      trapCause <= causeNxt;
    end
  end

  // R13
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strb));

  // R4
  trap_freezes_cwp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trapPulse |-> $stable(cwpIn));

  // R12
  no_cause_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trapPulse |-> (trapCause == TC_NONE));

  // R6
  rett_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdValid && cmdOp == OP_RETT && trapEn) |=> (trapPulse && trapCause == TC_ILL));
endmodule

// File: rtl/regwin_dp.sv
module regwin_dp
  import regwin_pkg::*;
#(
  parameter int NWIN = 8,
  localparam int CW = $clog2(NWIN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  winStrb_t        strb,
  input  logic [CW-1:0]   statCwp,
  input  logic            statEt,
  input  logic            statPs,
  input  logic            statS,
  input  logic            statEf,
  input  logic [3:0]      statPil,
  input  logic [NWIN-1:0] maskIn,
  output logic [CW-1:0]   cwp,
  output logic [NWIN-1:0] wim,
  output logic            sup,
  output logic            prevSup,
  output logic            trapEn,
  output logic            fpEn,
  output logic [3:0]      pil,
  output logic [CW-1:0]   cwpUp,
  output logic [CW-1:0]   cwpDn
);
  localparam logic [CW-1:0] TOPWIN = CW'(NWIN - 1);

  always_comb begin
    cwpUp = (cwp == TOPWIN) ? '0 : cwp + 1'b1;
    cwpDn = (cwp == '0) ? TOPWIN : cwp - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cwp     <= '0;
      wim     <= '0;
      sup     <= 1'b1;
      prevSup <= 1'b0;
      trapEn  <= 1'b0;
      fpEn    <= 1'b0;
      pil     <= '0;
    end else begin
      if (strb.moveDn) cwp <= cwpDn;
      if (strb.moveUp) cwp <= cwpUp;
      if (strb.rettDo) begin
        cwp    <= cwpUp;
        trapEn <= 1'b1;
        sup    <= prevSup;
      end
      if (strb.loadStat) begin
        cwp     <= statCwp;
        trapEn  <= statEt;
        prevSup <= statPs;
        sup     <= statS;
        fpEn    <= statEf;
        pil     <= statPil;
      end
      if (strb.loadMask) wim <= maskIn;
    end
  end

  // R2
  cwp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cwp <= TOPWIN);

  // R7
  rett_sets_et_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.rettDo |=> trapEn);

  // R13
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb == '0) |=> ($stable(cwp) && $stable(wim) && $stable(trapEn) && $stable(sup)));
endmodule

// File: rtl/regwin_ptr.sv
module regwin_ptr
  import regwin_pkg::*;
#(
  parameter int NWIN = 8,
  localparam int CW = $clog2(NWIN),
  localparam int DW = (NWIN > 13) ? NWIN : 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmdValid,
  input  logic [2:0]      cmdOp,
  input  logic [DW-1:0]   cmdData,
  output logic [CW-1:0]   cwpOut,
  output logic [NWIN-1:0] wimOut,
  output logic            supOut,
  output logic            prevSupOut,
  output logic            trapEnOut,
  output logic            fpEnOut,
  output logic [3:0]      pilOut,
  output logic            trapPulse,
  output logic [1:0]      trapCause
);
  winStrb_t      strb;
  logic [CW-1:0] cwpUp;
  logic [CW-1:0] cwpDn;

  regwin_ctrl #(.NWIN(NWIN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cwpField(cmdData[4:0]), .cwpIn(cwpOut), .cwpUp(cwpUp), .cwpDn(cwpDn),
    .wim(wimOut), .trapEn(trapEnOut), .strb(strb),
    .trapPulse(trapPulse), .trapCause(trapCause)
  );

  regwin_dp #(.NWIN(NWIN)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .statCwp(cmdData[CW-1:0]), .statEt(cmdData[ST_ET]), .statPs(cmdData[ST_PS]),
    .statS(cmdData[ST_S]), .statEf(cmdData[ST_EF]), .statPil(cmdData[ST_PIL +: 4]),
    .maskIn(cmdData[NWIN-1:0]),
    .cwp(cwpOut), .wim(wimOut), .sup(supOut), .prevSup(prevSupOut),
    .trapEn(trapEnOut), .fpEn(fpEnOut), .pil(pilOut),
    .cwpUp(cwpUp), .cwpDn(cwpDn)
  );
endmodule

// File: tb/sim_regwin_ptr.sv
`timescale 1ns/1ps
module sim_regwin_ptr;
  localparam int NW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmdValid = 1'b0;
  logic [2:0]  cmdOp = '0;
  logic [12:0] cmdData = '0;
  logic [2:0]  cwpOut;
  logic [7:0]  wimOut;
  logic        supOut, prevSupOut, trapEnOut, fpEnOut, trapPulse;
  logic [3:0]  pilOut;
  logic [1:0]  trapCause;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int         mCwp;
  logic [7:0] mWim;
  logic       mS, mPs, mEt, mEf, eTp;
  logic [3:0] mPil;
  logic [1:0] eCause;

  always #4 clk = ~clk;

  regwin_ptr #(.NWIN(NW)) u0 (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdData(cmdData),
    .cwpOut(cwpOut), .wimOut(wimOut), .supOut(supOut), .prevSupOut(prevSupOut),
    .trapEnOut(trapEnOut), .fpEnOut(fpEnOut), .pilOut(pilOut),
    .trapPulse(trapPulse), .trapCause(trapCause)
  );

  function automatic logic [12:0] mkStat(int c, logic et, logic ps, logic s,
                                         logic [3:0] pl, logic ef);
    return {ef, pl, s, ps, et, 5'(c)};
  endfunction

  task automatic checkAll(string tag);
    logic [21:0] act, exp;
    act = {cwpOut, wimOut, supOut, prevSupOut, trapEnOut, fpEnOut, pilOut, trapPulse, trapCause};
    exp = {3'(mCwp), mWim, mS, mPs, mEt, mEf, mPil, eTp, eCause};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model(int op, logic [12:0] d);
    int t;
    eTp = 0; eCause = 0;
    case (op)
      0: begin
        t = (mCwp + NW - 1) % NW;
        if (mWim[t]) begin eTp = 1; eCause = 1; end else mCwp = t;
      end
      1: begin
        t = (mCwp + 1) % NW;
        if (mWim[t]) begin eTp = 1; eCause = 2; end else mCwp = t;
      end
      2: begin
        t = (mCwp + 1) % NW;
        if (mEt) begin eTp = 1; eCause = 3; end
        else if (mWim[t]) begin eTp = 1; eCause = 2; end
        else begin mCwp = t; mEt = 1; mS = mPs; end
      end
      3: begin
        if (int'(d[4:0]) >= NW) begin eTp = 1; eCause = 3; end
        else begin
          mCwp = int'(d[4:0]); mEt = d[5]; mPs = d[6]; mS = d[7];
          mPil = d[11:8]; mEf = d[12];
        end
      end
      4: mWim = d[7:0];
      default: ;
    endcase
  endtask

  task automatic doCmd(int op, logic [12:0] d, string tag);
    @(negedge clk);
    cmdValid = 1; cmdOp = 3'(op); cmdData = d;
    model(op, d);
    @(posedge clk);
    #1 cmdValid = 0;
    @(negedge clk);
    checkAll(tag);
  endtask

  task automatic idleCheck(string tag);
    @(negedge clk);
    eTp = 0; eCause = 0;
    checkAll(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    mCwp = 0; mWim = 0; mS = 1; mPs = 0; mEt = 0; mEf = 0; mPil = 0; eTp = 0; eCause = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    checkAll("R1");

    for (int c = 0; c < NW; c++) begin
      for (int m = 0; m < 2; m++) begin
        int tDn, tUp;
        tDn = (c + NW - 1) % NW;
        tUp = (c + 1) % NW;
        // save: R2 / R4
        doCmd(3, mkStat(c, 0, m[0], 1, 4'(c), c[0]), "R10");
        doCmd(4, {5'b0, m ? 8'(1 << tDn) : ~8'(1 << tDn)}, "R11");
        doCmd(0, '0, m ? "R4" : "R2");
        if (m) idleCheck("R12");
        // restore: R3 / R5
        doCmd(3, mkStat(c, 0, 1, 0, 4'(15 - c), 1), "R10");
        doCmd(4, {5'b0, m ? 8'(1 << tUp) : ~8'(1 << tUp)}, "R11");
        doCmd(1, '0, m ? "R5" : "R3");
        if (m) idleCheck("R12");
        // return from trap with ET clear: R7 / R8
        doCmd(3, mkStat(c, 0, ~m[0], m[0], 4'(c + 3), 0), "R10");
        doCmd(1 + 3, {5'b0, m ? 8'(1 << tUp) : 8'h00}, "R11");
        doCmd(2, '0, m ? "R8" : "R7");
        // return from trap with ET set, target masked or not: R6
        doCmd(3, mkStat(c, 1, 1, 0, 4'(c), 1), "R10");
        doCmd(4, {5'b0, m ? 8'(1 << tUp) : 8'h00}, "R11");
        doCmd(2, '0, "R6");
        idleCheck("R12");
      end
    end

    // invalid pointer field in status write: R9
    doCmd(3, mkStat(2, 0, 1, 1, 4'h5, 0), "R10");
    for (int f = NW; f < 32; f++) begin
      doCmd(3, mkStat(f, 1, 0, 0, 4'(f), 1), "R9");
    end

    // unused op codes and idle cycles: R13
    for (int op = 5; op < 8; op++) begin
      doCmd(op, 13'h1fff, "R13");
      doCmd(op, 13'h0000, "R13");
    end
    idleCheck("R13");
    idleCheck("R13");

    // wrap runs: full circle down then up with empty mask: R2 R3
    doCmd(4, '0, "R11");
    for (int k = 0; k < NW + 1; k++) doCmd(0, '0, "R2");
    for (int k = 0; k < NW + 1; k++) doCmd(1, '0, "R3");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule